// File: doc/BRIEF.md
# Converter Configuration Register Bank

This block holds the setup of a delta-sigma converter in eleven byte-wide registers at addresses 0h to Ah. The registers are reached through a plain parallel port with an address, write data, a write strobe and a combinational read-data output. The decoded fields drive the converter directly: input channel pair, clock-out select, sensor-detect current, gain, data rate, analog buffer enable, general-purpose pin direction and level, and the two 24-bit calibration words.

A status register carries a read-only identity code and a live copy of the data-ready pin. It also holds three control bits: auto-calibration enable, buffer enable and output bit order. While auto-calibration is on, any write that alters the gain, the data rate or the buffer enable raises a one-cycle calibration request. A byte serializer sends bytes out; for each byte it takes its bit order from the status register at the moment the byte is loaded.

Top module: `adc_cfg_bank`

## Requirements
- R1: After reset, reads return status = {ID_CODE, 3'b000, data-ready pin}, channel register (addr 1h) = 01h, control register (addr 2h) = 20h, rate register (addr 3h) = F0h and pin register (addr 4h) = E0h when all pin inputs are low; the calibration bytes read 00h.
- R2: Writes to addresses 1h, 3h and 5h..Ah read back unchanged. A write to the control register (addr 2h) reads back with bit 7 forced to 0.
- R3: Status bits 7..4 always read ID_CODE and ignore writes. Status bit 0 always reads the live data-ready input.
- R4: Decoded outputs: pos_sel = chan[7:4], neg_sel = chan[3:0], clkout_sel = ctrl[6:5], sensor_cur = ctrl[4:3], gain = ctrl[2:0], rate = whole rate register, buf_en = status[1], auto_cal = status[2].
- R5: Pin register bits 7..4 are directions (1 = input) and bits 3..0 are levels. gpio_out carries the written levels. On a read, bit k of the low nibble returns gpio_in[k] when direction k is 1, and the written level otherwise.
- R6: offset_cal = {byte at 7h, byte at 6h, byte at 5h} and fscale_cal = {byte at Ah, byte at 9h, byte at 8h}, so the low byte sits at the lowest address.
- R7: Writes to addresses Bh..Fh change nothing, and reads from those addresses return 00h.
- R8: When a write leaves status bit 2 at 1 and changes gain, the rate register or buffer enable, cal_req is high for exactly the one cycle after that write's clock edge.
- R9: No calibration request is raised when auto-calibration is off after the write, when the written values equal the stored ones, or when only other fields change.
- R10: On ser_load the serializer presents the first bit of ser_byte on ser_bit: bit 7 when status bit 3 is 0, bit 0 when it is 1. Each ser_shift then advances one bit in that direction.
- R11: A change of status bit 3 while a byte is being shifted out does not affect that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per active cycle |
| rdata | output | 8 | Read data for addr |
| drdy_in | input | 1 | Data-ready pin level |
| gpio_in | input | 4 | Levels seen on the general-purpose pins |
| gpio_dir | output | 4 | Pin directions, 1 = input |
| gpio_out | output | 4 | Pin output levels |
| pos_sel | output | 4 | Positive input channel |
| neg_sel | output | 4 | Negative input channel |
| clkout_sel | output | 2 | Clock-out select |
| sensor_cur | output | 2 | Sensor-detect current select |
| gain | output | 3 | Gain code |
| rate | output | 8 | Data-rate code |
| buf_en | output | 1 | Analog input buffer enable |
| auto_cal | output | 1 | Auto-calibration enable |
| offset_cal | output | 24 | Offset calibration word |
| fscale_cal | output | 24 | Full-scale calibration word |
| cal_req | output | 1 | One-cycle self-calibration request |
| ser_load | input | 1 | Load ser_byte into the serializer |
| ser_byte | input | 8 | Byte to serialize |
| ser_shift | input | 1 | Advance the serializer by one bit |
| ser_bit | output | 1 | Current serial output bit |

## Verification
The bench builds the block with ID_CODE = 4'b1010. Its alternating bits expose a stuck, swapped or write-corrupted identity nibble that the default code would not show. SYNC_STAGES stays at its default of two, so the first write comes well after the reset release. The serializer patterns are chosen so that they are not bit-palindromes, which keeps a wrong or late-sampled order setting from going unnoticed.

// File: rtl/adcreg_pkg.sv
package adcreg_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int CAL_BYTES = 6;

  localparam logic [ADDR_W-1:0] A_STAT   = 4'h0;
  localparam logic [ADDR_W-1:0] A_CHAN   = 4'h1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h2;
  localparam logic [ADDR_W-1:0] A_RATE   = 4'h3;
  localparam logic [ADDR_W-1:0] A_PINS   = 4'h4;
  localparam logic [ADDR_W-1:0] A_CAL0   = 4'h5;
  localparam logic [ADDR_W-1:0] A_LAST   = A_CAL0 + CAL_BYTES - 1;

  localparam logic [DATA_W-1:0] RST_CHAN = 8'h01;
  localparam logic [6:0]        RST_CTRL = 7'h20;
  localparam logic [DATA_W-1:0] RST_RATE = 8'hF0;
  localparam logic [DATA_W-1:0] RST_PINS = 8'hE0;
endpackage

// File: rtl/adcreg_rst_sync.sv
module adcreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/adcreg_regs.sv
module adcreg_regs
  import adcreg_pkg::*;
#(
  parameter logic [3:0] ID_CODE = 4'h3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          wr_en,
  output logic [DATA_W-1:0]             rdata,
  input  logic                          drdy_in,
  input  logic [3:0]                    gpio_in,
  output logic                          order_lsb,
  output logic                          acal,
  output logic                          bufen,
  output logic [DATA_W-1:0]             chan,
  output logic [6:0]                    ctrl,
  output logic [DATA_W-1:0]             rate,
  output logic [3:0]                    pin_dir,
  output logic [3:0]                    pin_lvl,
  output logic [CAL_BYTES-1:0][DATA_W-1:0] cal_bytes,
  output logic                          cal_req
);
  logic                          order_q, order_d;
  logic                          acal_q, acal_d;
  logic                          bufen_q, bufen_d;
  logic [DATA_W-1:0]             chan_q, chan_d;
  logic [6:0]                    ctrl_q, ctrl_d;
  logic [DATA_W-1:0]             rate_q, rate_d;
  logic [3:0]                    dir_q, dir_d;
  logic [3:0]                    lvl_q, lvl_d;
  logic [CAL_BYTES-1:0][DATA_W-1:0] cal_q, cal_d;
  logic                          req_q, req_d;

  logic              in_cal;
  logic [ADDR_W-1:0] cal_off;
  logic              watched_change;

  assign in_cal  = (addr >= A_CAL0) && (addr <= A_LAST);
  assign cal_off = addr - A_CAL0;

  // next-state
  always_comb begin
    order_d = order_q;
    acal_d  = acal_q;
    bufen_d = bufen_q;
    chan_d  = chan_q;
    ctrl_d  = ctrl_q;
    rate_d  = rate_q;
    dir_d   = dir_q;
    lvl_d   = lvl_q;
    cal_d   = cal_q;
    if (wr_en) begin
      case (addr)
        A_STAT: {order_d, acal_d, bufen_d} = wdata[3:1];
        A_CHAN: chan_d = wdata;
        A_CTRL: ctrl_d = wdata[6:0];
        A_RATE: rate_d = wdata;
        A_PINS: {dir_d, lvl_d} = wdata;
        default: if (in_cal) cal_d[cal_off[2:0]] = wdata;
      endcase
    end
  end

  // calibration trigger: judged on the values the write leaves behind
  assign watched_change = (ctrl_d[2:0] != ctrl_q[2:0]) ||
                          (rate_d != rate_q) ||
                          (bufen_d != bufen_q);
  assign req_d = wr_en && acal_d && watched_change;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= 1'b0;
      acal_q  <= 1'b0;
      bufen_q <= 1'b0;
      chan_q  <= RST_CHAN;
      ctrl_q  <= RST_CTRL;
      rate_q  <= RST_RATE;
      dir_q   <= RST_PINS[7:4];
      lvl_q   <= RST_PINS[3:0];
      cal_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      order_q <= order_d;
      acal_q  <= acal_d;
      bufen_q <= bufen_d;
      chan_q  <= chan_d;
      ctrl_q  <= ctrl_d;
      rate_q  <= rate_d;
      dir_q   <= dir_d;
      lvl_q   <= lvl_d;
      cal_q   <= cal_d;
      req_q   <= req_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: rdata = {ID_CODE, order_q, acal_q, bufen_q, drdy_in};
      A_CHAN: rdata = chan_q;
      A_CTRL: rdata = {1'b0, ctrl_q};
      A_RATE: rdata = rate_q;
      A_PINS: rdata = {dir_q, (dir_q & gpio_in) | (~dir_q & lvl_q)};
      default: if (in_cal) rdata = cal_q[cal_off[2:0]];
    endcase
  end

  assign order_lsb = order_q;
  assign acal      = acal_q;
  assign bufen     = bufen_q;
  assign chan      = chan_q;
  assign ctrl      = ctrl_q;
  assign rate      = rate_q;
  assign pin_dir   = dir_q;
  assign pin_lvl   = lvl_q;
  assign cal_bytes = cal_q;
  assign cal_req   = req_q;
endmodule

// File: rtl/adcreg_ser.sv
module adcreg_ser #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] din,
  input  logic             lsb_first,
  output logic             dout
);
  logic [WIDTH-1:0] sh_q, sh_d;
  logic             lsb_q, lsb_d;

  always_comb begin
    sh_d  = sh_q;
    lsb_d = lsb_q;
    if (load) begin
      sh_d  = din;
      lsb_d = lsb_first;
    end else if (shift) begin
      if (lsb_q) sh_d = {1'b0, sh_q[WIDTH-1:1]};
      else       sh_d = {sh_q[WIDTH-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      lsb_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      lsb_q <= lsb_d;
    end
  end

  assign dout = lsb_q ? sh_q[0] : sh_q[WIDTH-1];
endmodule

// File: rtl/adc_cfg_bank.sv
module adc_cfg_bank
  import adcreg_pkg::*;
#(
  parameter logic [3:0] ID_CODE     = 4'h3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  output logic [7:0]  rdata,
  input  logic        drdy_in,
  input  logic [3:0]  gpio_in,
  output logic [3:0]  gpio_dir,
  output logic [3:0]  gpio_out,
  output logic [3:0]  pos_sel,
  output logic [3:0]  neg_sel,
  output logic [1:0]  clkout_sel,
  output logic [1:0]  sensor_cur,
  output logic [2:0]  gain,
  output logic [7:0]  rate,
  output logic        buf_en,
  output logic        auto_cal,
  output logic [23:0] offset_cal,
  output logic [23:0] fscale_cal,
  output logic        cal_req,
  input  logic        ser_load,
  input  logic [7:0]  ser_byte,
  input  logic        ser_shift,
  output logic        ser_bit
);
  localparam int HALF = CAL_BYTES / 2;

  logic                             rst_q_n;
  logic                             order_lsb;
  logic [DATA_W-1:0]                chan;
  logic [6:0]                       ctrl;
  logic [CAL_BYTES-1:0][DATA_W-1:0] cal_bytes;

  adcreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  adcreg_regs #(.ID_CODE(ID_CODE)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .drdy_in(drdy_in), .gpio_in(gpio_in),
    .order_lsb(order_lsb), .acal(auto_cal), .bufen(buf_en),
    .chan(chan), .ctrl(ctrl), .rate(rate),
    .pin_dir(gpio_dir), .pin_lvl(gpio_out),
    .cal_bytes(cal_bytes), .cal_req(cal_req)
  );

  adcreg_ser #(.WIDTH(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_q_n), .load(ser_load), .shift(ser_shift),
    .din(ser_byte), .lsb_first(order_lsb), .dout(ser_bit)
  );

  assign pos_sel    = chan[7:4];
  assign neg_sel    = chan[3:0];
  assign clkout_sel = ctrl[6:5];
  assign sensor_cur = ctrl[4:3];
  assign gain       = ctrl[2:0];
  assign offset_cal = cal_bytes[HALF-1:0];
  assign fscale_cal = cal_bytes[CAL_BYTES-1:HALF];
endmodule

// File: rtl/adc_cfg_bank_chk.sv
module adc_cfg_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] addr,
  input logic       wr_en,
  input logic [7:0] rdata,
  input logic       drdy_in,
  input logic       cal_req,
  input logic       auto_cal,
  input logic [2:0] gain,
  input logic [7:0] rate,
  input logic       buf_en,
  input logic       order_lsb,
  input logic       ser_load,
  input logic [7:0] ser_byte,
  input logic       ser_bit
);
  assert_cal_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> $past(wr_en));

  assert_cal_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> auto_cal);

  assert_no_cal_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !auto_cal) |-> !cal_req);

  assert_oob_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && ($past(addr) > 4'hA)) |->
      ($stable(gain) && $stable(rate) && $stable(buf_en) && !cal_req));

  assert_oob_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > 4'hA) |-> (rdata == 8'h00));

  assert_drdy_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'h0) |-> (rdata[0] == drdy_in));

  assert_first_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ser_load) |->
      (ser_bit == ($past(order_lsb) ? $past(ser_byte[0]) : $past(ser_byte[7]))));
endmodule

bind adc_cfg_bank adc_cfg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .addr(addr), .wr_en(wr_en), .rdata(rdata),
  .drdy_in(drdy_in), .cal_req(cal_req), .auto_cal(auto_cal), .gain(gain),
  .rate(rate), .buf_en(buf_en), .order_lsb(order_lsb), .ser_load(ser_load),
  .ser_byte(ser_byte), .ser_bit(ser_bit)
);

// File: tb/adc_cfg_bank_test.sv
module adc_cfg_bank_test;
  localparam logic [3:0] ID = 4'b1010;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic        wr_en;
  logic [7:0]  rdata;
  logic        drdy_in;
  logic [3:0]  gpio_in;
  logic [3:0]  gpio_dir, gpio_out, pos_sel, neg_sel;
  logic [1:0]  clkout_sel, sensor_cur;
  logic [2:0]  gain;
  logic [7:0]  rate;
  logic        buf_en, auto_cal, cal_req;
  logic [23:0] offset_cal, fscale_cal;
  logic        ser_load, ser_shift, ser_bit;
  logic [7:0]  ser_byte;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  adc_cfg_bank #(.ID_CODE(ID)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .drdy_in(drdy_in), .gpio_in(gpio_in), .gpio_dir(gpio_dir),
    .gpio_out(gpio_out), .pos_sel(pos_sel), .neg_sel(neg_sel),
    .clkout_sel(clkout_sel), .sensor_cur(sensor_cur), .gain(gain),
    .rate(rate), .buf_en(buf_en), .auto_cal(auto_cal),
    .offset_cal(offset_cal), .fscale_cal(fscale_cal), .cal_req(cal_req),
    .ser_load(ser_load), .ser_byte(ser_byte), .ser_shift(ser_shift),
    .ser_bit(ser_bit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // write, then check the request pulse in the following cycle and its end
  task automatic wr_cal(input logic [3:0] a, input logic [7:0] d,
                        input logic exp, input string req);
    wr(a, d);
    check(req, cal_req, exp);
    @(negedge clk);
    check(req, cal_req, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic test_reset;
    rd(4'h0, {ID, 4'b0001}, "R1 status");
    rd(4'h1, 8'h01, "R1 chan");
    rd(4'h2, 8'h20, "R1 ctrl");
    rd(4'h3, 8'hF0, "R1 rate");
    rd(4'h4, 8'hE0, "R1 pins");
    rd(4'h7, 8'h00, "R1 cal");
    check("R1 gain", gain, 3'd0);
    check("R1 buf", buf_en, 1'b0);
    check("R1 cal_req", cal_req, 1'b0);
    check("R4 neg reset", neg_sel, 4'h1);
    check("R4 clkout reset", clkout_sel, 2'b01);
  endtask

  task automatic test_status;
    wr(4'h0, 8'h50);
    rd(4'h0, {ID, 4'b0001}, "R3 id kept");
    drdy_in = 1'b0;
    rd(4'h0, {ID, 4'b0000}, "R3 drdy low");
    drdy_in = 1'b1;
    rd(4'h0, {ID, 4'b0001}, "R3 drdy high");
  endtask

  task automatic test_fields;
    wr_cal(4'h1, 8'h37, 1'b0, "R9 chan");
    wr_cal(4'h2, 8'hFD, 1'b0, "R9 acal off");
    wr(4'h3, 8'h82);
    rd(4'h1, 8'h37, "R2 chan");
    rd(4'h2, 8'h7D, "R2 ctrl bit7");
    rd(4'h3, 8'h82, "R2 rate");
    check("R4 pos", pos_sel, 4'h3);
    check("R4 neg", neg_sel, 4'h7);
    check("R4 clkout", clkout_sel, 2'b11);
    check("R4 sensor", sensor_cur, 2'b11);
    check("R4 gain", gain, 3'd5);
    check("R4 rate", rate, 8'h82);
  endtask

  task automatic test_pins;
    gpio_in = 4'b0101;
    wr(4'h4, 8'h3A);
    rd(4'h4, 8'h39, "R5 mixed read");
    check("R5 out", gpio_out, 4'hA);
    check("R5 dir", gpio_dir, 4'h3);
    gpio_in = 4'b0010;
    rd(4'h4, 8'h3A, "R5 input follows pin");
  endtask

  task automatic test_calwords;
    for (int i = 0; i < 6; i++) wr(4'(5 + i), 8'(8'h11 * (i + 1)));
    check("R6 offset", offset_cal, 24'h332211);
    check("R6 fscale", fscale_cal, 24'h665544);
    rd(4'h6, 8'h22, "R2 cal readback");
    rd(4'hA, 8'h66, "R2 cal top");
  endtask

  task automatic test_oob;
    for (int a = 11; a < 16; a++) begin
      wr_cal(4'(a), 8'hFF, 1'b0, "R7 no cal");
      rd(4'(a), 8'h00, "R7 read zero");
    end
    rd(4'h3, 8'h82, "R7 rate kept");
    rd(4'h1, 8'h37, "R7 chan kept");
    rd(4'h0, {ID, 4'b0001}, "R7 status kept");
    check("R7 gain", gain, 3'd5);
  endtask

  task automatic test_autocal;
    wr_cal(4'h0, 8'h04, 1'b0, "R9 enable only");
    check("R4 auto_cal", auto_cal, 1'b1);
    wr_cal(4'h2, 8'hFD, 1'b0, "R9 same ctrl");
    wr_cal(4'h2, 8'hFE, 1'b1, "R8 gain change");
    wr_cal(4'h2, 8'h86, 1'b0, "R9 other ctrl bits");
    wr_cal(4'h3, 8'h82, 1'b0, "R9 same rate");
    wr_cal(4'h3, 8'h13, 1'b1, "R8 rate change");
    wr_cal(4'h1, 8'h12, 1'b0, "R9 chan change");
    wr_cal(4'h0, 8'h06, 1'b1, "R8 buffer change");
    check("R4 buf", buf_en, 1'b1);
    wr_cal(4'h0, 8'h02, 1'b0, "R9 disable");
    wr_cal(4'h2, 8'hF9, 1'b0, "R9 gain while off");
  endtask

  task automatic serial_byte(input logic [7:0] b, input logic lsb, input string req);
    @(negedge clk);
    ser_byte = b; ser_load = 1'b1;
    @(negedge clk);
    ser_load = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check(req, ser_bit, lsb ? b[i] : b[7-i]);
      ser_shift = 1'b1;
      @(negedge clk);
      ser_shift = 1'b0;
    end
  endtask

  task automatic test_serial;
    serial_byte(8'hC2, 1'b0, "R10 msb first");
    wr(4'h0, 8'h0A);
    serial_byte(8'hC2, 1'b1, "R10 lsb first");
  endtask

  task automatic test_order_capture;
    logic [7:0] b;
    b = 8'h0F;
    @(negedge clk);
    ser_byte = b; ser_load = 1'b1;
    @(negedge clk);
    ser_load = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i == 3) wr(4'h0, 8'h02);
      check("R11 order held", ser_bit, b[i]);
      ser_shift = 1'b1;
      @(negedge clk);
      ser_shift = 1'b0;
    end
    rd(4'h0, {ID, 4'b0011}, "R11 order cleared");
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0;
    drdy_in = 1'b1; gpio_in = '0;
    ser_load = 1'b0; ser_shift = 1'b0; ser_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_status();
    test_fields();
    test_pins();
    test_calwords();
    test_oob();
    test_autocal();
    test_serial();
    test_order_capture();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule